// File: doc/BRIEF.md
# Hall Edge Tachometer and Direction Detector

This block watches the three Hall position lines of a brushless motor and derives two speed and direction signals from them. Any change of the three-bit Hall code starts, or restarts, a retriggerable one-shot. The one-shot counts system clocks, so the resulting pulse train has a frequency that follows motor speed. Its width is a programmable on-time, which should be set shorter than the shortest expected gap between Hall changes. A downstream filter or a timer can then turn this pulse train into a speed estimate.

The direction output comes from comparing each new Hall code with the one before it. The six legal codes form a ring. A step one place forward along the ring marks one rotation sense, and a step one place backward marks the other. Each legal step gives a one-cycle step strobe. A step that leaves or enters an illegal code, or that skips a position, leaves the direction unchanged and gives a one-cycle error strobe.

The Hall inputs are expected to be already synchronized to `clk`. Reset is synchronous and active high.

Top module: `hall_tach_dir`

## Requirements
- R1: While reset is asserted and in the first cycle after it, tach_out is 0, dir_out is 0, step_stb is 0 and seq_err is 0.
- R2: Once primed, the block responds to any change of the hall code, whether a line rises or falls. The one-shot then loads on_time, and tach_out is high for exactly on_time clock cycles, starting one cycle after the changed code is first sampled.
- R3: A hall change that arrives while tach_out is high reloads the full on_time, so the pulse ends on_time cycles after the latest change.
- R4: A hall change that arrives while on_time is 0 produces no tach_out pulse.
- R5: The forward ring is 101 (position 0), 100 (1), 110 (2), 010 (3), 011 (4), 001 (5), and after position 5 it returns to position 0. A change to the next position on this ring, including 001→101, sets dir_out to 1 and pulses step_stb for one cycle. Both take effect one cycle after the change.
- R6: A change to the previous position on the ring, including 101→001, sets dir_out to 0 and pulses step_stb for one cycle.
- R7: Three kinds of change count as illegal: a change into 000 or 111, a change out of 000 or 111, and a change between two legal codes that are not neighbours on the ring. For an illegal change, dir_out keeps its value, step_stb stays 0, seq_err pulses for one cycle, and the one-shot still triggers as in R2.
- R8: After reset, no hall change triggers a pulse or a strobe until a legal code has been sampled once. That first legal code is captured without any pulse or strobe.
- R9: step_stb and seq_err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hall | input | 3 | Synchronized Hall code, bit 2 = first sensor |
| on_time | input | ONTIME_W | One-shot width in clock cycles |
| tach_out | output | 1 | Retriggerable tachometer pulse |
| dir_out | output | 1 | Decoded rotation direction |
| step_stb | output | 1 | One-cycle strobe on a legal ring step |
| seq_err | output | 1 | One-cycle strobe on an illegal hall change |

## Verification
Two functions can act in the same cycle: the one-shot and the direction tracker. Every hall change triggers both, so a single sample must show the tachometer reload together with either a step strobe or an error strobe. The bench provokes this in two ways. It changes the code while a pulse is still running, which tests the reload. It also makes illegal and skipping changes in the middle of a pulse. For each case it checks, in the same cycle, that tach_out restarts its full width, that dir_out holds or flips as the ring position requires, and that exactly one of the two strobes fires.

// File: rtl/hall_pkg.sv
package hall_pkg;
    localparam int HALL_W = 3;
    localparam int NPOS   = 6;
    localparam int IDX_W  = $clog2(NPOS);

    typedef logic [HALL_W-1:0] hcode_t;
    typedef logic [IDX_W-1:0]  hidx_t;

    // A legal position code has neither all lines low nor all lines high.
    function automatic logic code_legal(hcode_t c);
        return (c != '0) && (c != '1);
    endfunction

    // Ring position of a legal code; the order follows the rotation sequence.
    function automatic hidx_t code_pos(hcode_t c);
        case (c)
            3'b101:  return hidx_t'(0);
            3'b100:  return hidx_t'(1);
            3'b110:  return hidx_t'(2);
            3'b010:  return hidx_t'(3);
            3'b011:  return hidx_t'(4);
            3'b001:  return hidx_t'(5);
            default: return hidx_t'(0);
        endcase
    endfunction

    function automatic hidx_t pos_inc(hidx_t i);
        return (i == hidx_t'(NPOS - 1)) ? hidx_t'(0) : hidx_t'(i + hidx_t'(1));
    endfunction
endpackage

// File: rtl/hall_step_classify.sv
module hall_step_classify
    import hall_pkg::*;
(
    input  hcode_t prev_code,
    input  hcode_t cur_code,
    output logic   is_fwd,
    output logic   is_rev
);
    logic  both_legal;
    hidx_t prev_pos;
    hidx_t cur_pos;

    always_comb begin
        both_legal = code_legal(prev_code) && code_legal(cur_code);
        prev_pos   = code_pos(prev_code);
        cur_pos    = code_pos(cur_code);
        is_fwd     = both_legal && (pos_inc(prev_pos) == cur_pos);
        is_rev     = both_legal && (pos_inc(cur_pos) == prev_pos);
    end
endmodule

// File: rtl/tach_oneshot.sv
module tach_oneshot #(
    parameter int ONTIME_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig,
    input  logic [ONTIME_W-1:0] load_val,
    output logic                pulse
);
    typedef struct packed {
        logic [ONTIME_W-1:0] cnt;
    } os_state_t;

    os_state_t os_d, os_q;

    always_comb begin
        os_d = os_q;
        if (trig) begin
            os_d.cnt = load_val;
        end else if (os_q.cnt != '0) begin
            os_d.cnt = os_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign pulse = (os_q.cnt != '0);
endmodule

// File: rtl/dir_tracker.sv
module dir_tracker (
    input  logic clk,
    input  logic rst,
    input  logic change,
    input  logic is_fwd,
    input  logic is_rev,
    output logic dir,
    output logic step,
    output logic err
);
    typedef struct packed {
        logic dir;
        logic step;
        logic err;
    } dt_state_t;

    dt_state_t dt_d, dt_q;

    always_comb begin
        dt_d      = dt_q;
        dt_d.step = 1'b0;
        dt_d.err  = 1'b0;
        if (change) begin
            if (is_fwd) begin
                dt_d.dir  = 1'b1;
                dt_d.step = 1'b1;
            end else if (is_rev) begin
                dt_d.dir  = 1'b0;
                dt_d.step = 1'b1;
            end else begin
                dt_d.err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dt_q <= '0;
        end else begin
            dt_q <= dt_d;
        end
    end

    assign dir  = dt_q.dir;
    assign step = dt_q.step;
    assign err  = dt_q.err;
endmodule

// File: rtl/hall_tach_dir.sv
module hall_tach_dir
    import hall_pkg::*;
#(
    parameter int ONTIME_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          hall,
    input  logic [ONTIME_W-1:0] on_time,
    output logic                tach_out,
    output logic                dir_out,
    output logic                step_stb,
    output logic                seq_err
);
    typedef struct packed {
        hcode_t code;
        logic   ok;
    } cap_state_t;

    cap_state_t cap_d, cap_q;
    logic       hall_edge;
    logic       primed;
    logic       fwd_w;
    logic       rev_w;

    // Previous-code register: idle until the first legal code, then follows hall.
    always_comb begin
        cap_d = cap_q;
        if (!cap_q.ok) begin
            if (code_legal(hall)) begin
                cap_d.code = hall;
                cap_d.ok   = 1'b1;
            end
        end else begin
            cap_d.code = hall;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign primed    = cap_q.ok;
    assign hall_edge = primed && (hall != cap_q.code);

    hall_step_classify u_cls (
        .prev_code (cap_q.code),
        .cur_code  (hall),
        .is_fwd    (fwd_w),
        .is_rev    (rev_w)
    );

    tach_oneshot #(.ONTIME_W(ONTIME_W)) u_os (
        .clk      (clk),
        .rst      (rst),
        .trig     (hall_edge),
        .load_val (on_time),
        .pulse    (tach_out)
    );

    dir_tracker u_dir (
        .clk    (clk),
        .rst    (rst),
        .change (hall_edge),
        .is_fwd (fwd_w),
        .is_rev (rev_w),
        .dir    (dir_out),
        .step   (step_stb),
        .err    (seq_err)
    );
endmodule

// File: rtl/hall_tach_dir_chk.sv
module hall_tach_dir_chk #(
    parameter int ONTIME_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                hall_edge,
    input logic                primed,
    input logic [ONTIME_W-1:0] on_time,
    input logic                tach_out,
    input logic                dir_out,
    input logic                step_stb,
    input logic                seq_err
);
    assert_edge_fires_R2: assert property (@(posedge clk) disable iff (rst)
        (hall_edge && (on_time != '0)) |=> tach_out);

    assert_no_pulse_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (hall_edge && (on_time == '0)) |=> !tach_out);

    assert_rise_needs_edge_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tach_out) |-> $past(hall_edge));

    assert_err_holds_dir_R7: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> $stable(dir_out));

    assert_step_needs_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (step_stb || seq_err) |-> $past(hall_edge));

    assert_silent_unprimed_R8: assert property (@(posedge clk) disable iff (rst)
        !primed |=> (!step_stb && !seq_err && !tach_out));

    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $countones({step_stb, seq_err}) <= 1);
endmodule

bind hall_tach_dir hall_tach_dir_chk #(.ONTIME_W(ONTIME_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hall_edge (hall_edge),
    .primed    (primed),
    .on_time   (on_time),
    .tach_out  (tach_out),
    .dir_out   (dir_out),
    .step_stb  (step_stb),
    .seq_err   (seq_err)
);

// File: tb/hall_tach_dir_tb.sv
module hall_tach_dir_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   hall = 3'b000;
    logic [W-1:0] on_time = '0;
    logic         tach_out, dir_out, step_stb, seq_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        int    due;
        logic  tach;
        logic  dir;
        logic  step;
        logic  err;
        string req;
    } exp_t;

    exp_t sb[$];

    // bench reference model state
    int       m_cnt = 0;
    logic     m_dir = 1'b0;
    logic [2:0] m_prev = 3'b000;
    logic     m_ok = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hall_tach_dir #(.ONTIME_W(W)) u_dut (
        .clk(clk), .rst(rst), .hall(hall), .on_time(on_time),
        .tach_out(tach_out), .dir_out(dir_out), .step_stb(step_stb), .seq_err(seq_err)
    );

    function automatic int ring_pos(logic [2:0] c);
        logic [2:0] ring [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        for (int i = 0; i < 6; i++) if (ring[i] == c) return i;
        return -1;
    endfunction

    // Driver: apply one hall sample, advance the model, queue the expected outputs.
    task automatic drive(input logic [2:0] h, input int ot, input string req);
        logic chg, stp, er;
        int pp, cp;
        @(negedge clk);
        hall    = h;
        on_time = W'(ot);
        chg = m_ok && (h != m_prev);
        stp = 1'b0;
        er  = 1'b0;
        if (chg) begin
            pp = ring_pos(m_prev);
            cp = ring_pos(h);
            if (pp >= 0 && cp >= 0 && cp == (pp + 1) % 6) begin
                m_dir = 1'b1; stp = 1'b1;
            end else if (pp >= 0 && cp >= 0 && pp == (cp + 1) % 6) begin
                m_dir = 1'b0; stp = 1'b1;
            end else begin
                er = 1'b1;
            end
            m_cnt = ot;
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
        end
        if (!m_ok) begin
            if (ring_pos(h) >= 0) begin
                m_prev = h; m_ok = 1'b1;
            end
        end else begin
            m_prev = h;
        end
        sb.push_back('{due: cyc + 1, tach: (m_cnt != 0), dir: m_dir,
                       step: stp, err: er, req: req});
    endtask

    task automatic hold(input logic [2:0] h, input int ot, input int n, input string req);
        for (int i = 0; i < n; i++) drive(h, ot, req);
    endtask

    // Monitor: compare queued expectations in the cycle they fall due.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if ({tach_out, dir_out, step_stb, seq_err} !== {e.tach, e.dir, e.step, e.err}) begin
                fails++;
                $display("FAIL %s cyc %0d: tach/dir/step/err actual %b%b%b%b expected %b%b%b%b",
                         e.req, cyc, tach_out, dir_out, step_stb, seq_err,
                         e.tach, e.dir, e.step, e.err);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++; // R1 reset state
        if ({tach_out, dir_out, step_stb, seq_err} !== 4'b0000) begin
            fails++;
            $display("FAIL R1: actual %b%b%b%b expected 0000", tach_out, dir_out, step_stb, seq_err);
        end
        rst = 1'b0;

        // R1 first cycle out of reset, R8 illegal codes before priming
        drive(3'b000, 5, "R1");
        drive(3'b111, 5, "R8");
        drive(3'b000, 5, "R8");
        hold(3'b101, 5, 3, "R8");

        // R5 forward steps, R2 full pulse width for rising and falling lines
        hold(3'b100, 5, 8, "R5_R2");
        hold(3'b110, 5, 8, "R5_R2");
        // R3 retrigger during pulse
        hold(3'b010, 5, 2, "R3");
        hold(3'b011, 5, 8, "R3");

        // R6 reverse steps
        hold(3'b010, 5, 3, "R6");
        hold(3'b110, 5, 8, "R6");

        // R7 into and out of illegal code, then a skip, during a pulse (R9)
        hold(3'b111, 5, 2, "R7_R9");
        hold(3'b110, 5, 2, "R7_R9");
        hold(3'b011, 5, 8, "R7");
        hold(3'b000, 5, 2, "R7");
        hold(3'b011, 5, 8, "R7");

        // R4 zero on-time, R5 wrap 001 -> 101
        hold(3'b001, 0, 4, "R4");
        hold(3'b101, 3, 6, "R5");
        // R6 wrap 101 -> 001
        hold(3'b001, 3, 6, "R6");

        // R3 back-to-back changes every cycle
        drive(3'b011, 4, "R3");
        drive(3'b010, 4, "R3");
        drive(3'b110, 4, "R3");
        hold(3'b100, 4, 7, "R3");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule